// File: doc/BRIEF.md
# Basic Up-Counting Timer with Preload

A general-purpose time base for a chip subsystem. A free-running input clock is divided by a programmable prescaler, and the divided ticks drive a counter. The counter climbs from zero to an auto-reload limit. On the tick after it reaches the limit, it returns to zero and produces an update event. The update event sets a sticky flag and can raise an interrupt request. It also copies the buffered prescaler value, and the buffered limit when buffering is on, into the registers that are in use.

Software sees six word registers on a simple write-strobe bus with a combinational read port:

| Address | Register |
|---|---|
| 0 | Control |
| 1 | Status |
| 2 | Event (software update) |
| 3 | Counter |
| 4 | Prescaler |
| 5 | Reload |

The control register holds these options:

| Bit | Option |
|---|---|
| 0 | Run |
| 1 | Single-shot |
| 2 | Reload buffering |
| 3 | Update suppress |
| 4 | Overflow-only flag source |
| 5 | Freeze on debug halt |
| 6 | Interrupt enable |

A debug-halt input freezes the count while bit 5 is set.

Top module: `basic_timer`

## Requirements
- R1: After reset the control, status, counter and prescaler registers read 0, the reload register reads all ones, and irq and upd_pulse are 0.
- R2: The counter first increments on the clock edge after the edge that writes run (control bit 0) to 1. It then increments once per prescaler tick, and the counter register (address 3) reads its current value.
- R3: On the tick where the counter equals the active reload value, it goes to 0 and an update event occurs. The update event sets status bit 0, and upd_pulse is 1 for one cycle after that edge.
- R4: The prescaler divides the clock by P+1, where P is the value in use. A value written to address 4 is only put into use at an update event.
- R5: With reload buffering (control bit 2) at 1, a reload write (address 5) takes effect at the next update event. With the bit at 0, it takes effect at once.
- R6: With single-shot (control bit 1) at 1, an update event clears run, and the counter stays where it stopped.
- R7: Writing 1 to bit 0 of address 2 sets the counter and the prescaler count to 0 and loads the buffered values. It also sets the flag unless overflow-only is on. Address 2 always reads 0.
- R8: With update suppress (control bit 3) at 1, the counter still wraps to 0, but no update event occurs: no flag, no upd_pulse and no transfer of buffered values.
- R9: With overflow-only (control bit 4) at 1, a software update reloads the counter and prescaler but leaves the flag clear. A counter wrap still sets the flag.
- R10: Writing 0 to status bit 0 clears the flag, and writing 1 leaves it unchanged. irq is 1 exactly when the flag and interrupt enable (control bit 6) are both 1.
- R11: While dbg_halt is 1 and freeze (control bit 5) is 1, the counter and prescaler hold their values. With freeze at 0, dbg_halt has no effect.
- R12: Control bits above bit 6 read 0 whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the timer and its registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_halt | input | 1 | Core-halted indication, used only while freeze is enabled |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | DATA_W (16) | Register write data |
| bus_rdata | output | DATA_W (16) | Combinational read data for bus_addr |
| upd_pulse | output | 1 | One-cycle pulse following each update event |
| irq | output | 1 | Update interrupt request |

## Verification
The bench checks the exact edge at which counting begins and the tick that wraps. A design one cycle late on either would be caught, and so would one that wraps a count early or late. It writes a new prescaler and a new reload value in mid-run with buffering on and with it off. A design that transferred at the wrong moment would show a wrong count after the first wrap. It also runs single-shot, update suppress, overflow-only and the debug freeze. A design that got any of these wrong would keep running, raise a stray flag, or count through a halt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
   localparam logic [ADDR_W-1:0] A_EVT  = 3'd2;
   localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
   localparam logic [ADDR_W-1:0] A_PSC  = 3'd4;
   localparam logic [ADDR_W-1:0] A_RLD  = 3'd5;

   localparam int unsigned B_RUN     = 0;
   localparam int unsigned B_SINGLE  = 1;
   localparam int unsigned B_BUF     = 2;
   localparam int unsigned B_NOUPD   = 3;
   localparam int unsigned B_OVFONLY = 4;
   localparam int unsigned B_FRZ     = 5;
   localparam int unsigned B_IE      = 6;
   localparam int unsigned CTRL_BITS = 7;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int unsigned PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [PSC_W-1:0] wdata,
   input  logic             enable,
   input  logic             clear,
   input  logic             load,
   output logic [PSC_W-1:0] pre_q,
   output logic             tick
);
   logic [PSC_W-1:0] div_cnt;
   logic [PSC_W-1:0] act_q;

   assign tick = enable && (div_cnt == act_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q   <= '0;
         act_q   <= '0;
         div_cnt <= '0;
      end else begin
         if (wr)
            pre_q <= wdata;
         if (load)
            act_q <= pre_q;
         if (clear)
            div_cnt <= '0;
         else if (enable)
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/tmr_reload.sv
module tmr_reload #(
   parameter int unsigned     CNT_W      = 16,
   parameter bit              PRELOAD_EN = 1'b1,
   parameter logic [CNT_W-1:0] RST_VAL   = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             buf_en,
   input  logic             load,
   output logic [CNT_W-1:0] pre_q,
   output logic [CNT_W-1:0] act_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= RST_VAL;
      else if (wr)
         pre_q <= wdata;
   end

   generate
      if (PRELOAD_EN) begin : g_shadow
         logic [CNT_W-1:0] shadow_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               shadow_q <= RST_VAL;
            else if (wr && !buf_en)
               shadow_q <= wdata;
            else if (load)
               shadow_q <= pre_q;
         end
         assign act_q = shadow_q;
      end else begin : g_direct
         assign act_q = pre_q;
      end
   endgenerate
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clear,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   assign wrap = tick && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (wr)
         cnt <= wdata;
      else if (clear)
         cnt <= '0;
      else if (tick)
         cnt <= wrap ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/basic_timer.sv
module basic_timer
   import tmr_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned PSC_W      = 16,
   parameter bit          PRELOAD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_halt,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              upd_pulse,
   output logic              irq
);
   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("basic_timer: CNT_W must lie in 2..DATA_W");
      end
      if (PSC_W < 1 || PSC_W > DATA_W) begin : g_bad_psc_w
         $error("basic_timer: PSC_W must lie in 1..DATA_W");
      end
      if (DATA_W < CTRL_BITS) begin : g_bad_data_w
         $error("basic_timer: DATA_W too narrow for control register");
      end
   endgenerate

   logic ctl_run, ctl_single, ctl_buf, ctl_noupd, ctl_ovfonly, ctl_frz, ctl_ie;
   logic buf_eff, flag;
   logic wr_ctrl, wr_stat, wr_cnt, wr_psc, wr_rld, ug_req;
   logic freeze, cnt_en, tick, wrap, ue, flag_set;
   logic [CNT_W-1:0] cnt, rld_pre, rld_act;
   logic [PSC_W-1:0] psc_pre;

   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign wr_stat = bus_wr && (bus_addr == A_STAT);
   assign wr_cnt  = bus_wr && (bus_addr == A_CNT);
   assign wr_psc  = bus_wr && (bus_addr == A_PSC);
   assign wr_rld  = bus_wr && (bus_addr == A_RLD);
   assign ug_req  = bus_wr && (bus_addr == A_EVT) && bus_wdata[0];

   assign buf_eff  = PRELOAD_EN && ctl_buf;
   assign freeze   = dbg_halt && ctl_frz;
   assign cnt_en   = ctl_run && !freeze;
   assign ue       = (wrap || ug_req) && !ctl_noupd;
   assign flag_set = ue && (wrap || !ctl_ovfonly);
   assign irq      = flag && ctl_ie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_run     <= 1'b0;
         ctl_single  <= 1'b0;
         ctl_buf     <= 1'b0;
         ctl_noupd   <= 1'b0;
         ctl_ovfonly <= 1'b0;
         ctl_frz     <= 1'b0;
         ctl_ie      <= 1'b0;
         flag        <= 1'b0;
         upd_pulse   <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctl_run     <= bus_wdata[B_RUN];
            ctl_single  <= bus_wdata[B_SINGLE];
            ctl_buf     <= bus_wdata[B_BUF];
            ctl_noupd   <= bus_wdata[B_NOUPD];
            ctl_ovfonly <= bus_wdata[B_OVFONLY];
            ctl_frz     <= bus_wdata[B_FRZ];
            ctl_ie      <= bus_wdata[B_IE];
         end else if (ue && ctl_single) begin
            ctl_run <= 1'b0;
         end
         if (flag_set)
            flag <= 1'b1;
         else if (wr_stat && !bus_wdata[0])
            flag <= 1'b0;
         upd_pulse <= ue;
      end
   end

   tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_psc),
      .wdata  (bus_wdata[PSC_W-1:0]),
      .enable (cnt_en),
      .clear  (ug_req),
      .load   (ue),
      .pre_q  (psc_pre),
      .tick   (tick)
   );

   tmr_reload #(.CNT_W(CNT_W), .PRELOAD_EN(PRELOAD_EN), .RST_VAL('1)) u_rld (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_rld),
      .wdata  (bus_wdata[CNT_W-1:0]),
      .buf_en (buf_eff),
      .load   (ue),
      .pre_q  (rld_pre),
      .act_q  (rld_act)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .clear (ug_req),
      .wr    (wr_cnt),
      .wdata (bus_wdata[CNT_W-1:0]),
      .limit (rld_act),
      .cnt   (cnt),
      .wrap  (wrap)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: begin
            bus_rdata[B_RUN]     = ctl_run;
            bus_rdata[B_SINGLE]  = ctl_single;
            bus_rdata[B_BUF]     = buf_eff;
            bus_rdata[B_NOUPD]   = ctl_noupd;
            bus_rdata[B_OVFONLY] = ctl_ovfonly;
            bus_rdata[B_FRZ]     = ctl_frz;
            bus_rdata[B_IE]      = ctl_ie;
         end
         A_STAT:  bus_rdata[0] = flag;
         A_CNT:   bus_rdata[CNT_W-1:0] = cnt;
         A_PSC:   bus_rdata[PSC_W-1:0] = psc_pre;
         A_RLD:   bus_rdata[CNT_W-1:0] = rld_pre;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/basic_timer_chk.sv
module basic_timer_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             freeze,
   input logic             ctl_run,
   input logic             ctl_single,
   input logic             ctl_noupd,
   input logic             ug_req,
   input logic             wr_ctrl,
   input logic             wr_cnt,
   input logic             tick,
   input logic             wrap,
   input logic             ue,
   input logic             flag,
   input logic             upd_pulse,
   input logic [CNT_W-1:0] cnt
);
   // R2: a non-wrapping tick advances the count by exactly one
   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wrap && !wr_cnt && !ug_req) |=> cnt == CNT_W'($past(cnt) + 1'b1));

   // R3: a wrap leaves the counter at zero
   p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !wr_cnt) |=> cnt == '0);

   // R3: a wrap with updates allowed raises the flag
   p_wrap_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !ctl_noupd) |=> flag);

   // R6: single-shot stops the counter at an update
   p_single_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ue && ctl_single && !wr_ctrl) |=> !ctl_run);

   // R7: software update restarts the count
   p_ug_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ug_req |=> cnt == '0);

   // R8: suppressed updates never pulse
   p_noupd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_noupd |=> !upd_pulse);

   // R11: frozen counter holds
   p_freeze_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !wr_cnt && !ug_req) |=> $stable(cnt));
endmodule

bind basic_timer basic_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .freeze     (freeze),
   .ctl_run    (ctl_run),
   .ctl_single (ctl_single),
   .ctl_noupd  (ctl_noupd),
   .ug_req     (ug_req),
   .wr_ctrl    (wr_ctrl),
   .wr_cnt     (wr_cnt),
   .tick       (tick),
   .wrap       (wrap),
   .ue         (ue),
   .flag       (flag),
   .upd_pulse  (upd_pulse),
   .cnt        (cnt)
);

// File: tb/tb_basic_timer.sv
module tb_basic_timer;
   import tmr_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_halt = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        upd_pulse;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   basic_timer dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .dbg_halt  (dbg_halt),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .upd_pulse (upd_pulse),
      .irq       (irq)
   );

   localparam logic [15:0] RUN  = 16'h0001;
   localparam logic [15:0] SGL  = 16'h0002;
   localparam logic [15:0] BUF  = 16'h0004;
   localparam logic [15:0] NOUP = 16'h0008;
   localparam logic [15:0] OVFO = 16'h0010;
   localparam logic [15:0] FRZ  = 16'h0020;
   localparam logic [15:0] IE   = 16'h0040;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // called at a negedge; the write lands on the next posedge; returns at the following negedge
   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      rd_chk(A_CTRL, 16'h0000, "R1 ctrl");
      rd_chk(A_STAT, 16'h0000, "R1 stat");
      rd_chk(A_CNT,  16'h0000, "R1 cnt");
      rd_chk(A_PSC,  16'h0000, "R1 psc");
      rd_chk(A_RLD,  16'hFFFF, "R1 reload");
      chk("R1 irq", {15'b0, irq}, 16'h0000);
      chk("R1 upd_pulse", {15'b0, upd_pulse}, 16'h0000);
   endtask

   task automatic t_basic;
      wr(A_RLD, 16'd5);
      wr(A_CTRL, RUN | IE);
      rd_chk(A_CNT, 16'd0, "R2 no count on enable edge");
      wait_n(3);
      rd_chk(A_CNT, 16'd3, "R2 count");
      wait_n(3);
      rd_chk(A_CNT, 16'd0, "R3 wrap");
      rd_chk(A_STAT, 16'd1, "R3 flag");
      chk("R3 upd_pulse", {15'b0, upd_pulse}, 16'h0001);
      chk("R10 irq set", {15'b0, irq}, 16'h0001);
      wr(A_STAT, 16'h0000);
      chk("R10 irq cleared", {15'b0, irq}, 16'h0000);
      chk("R3 pulse one cycle", {15'b0, upd_pulse}, 16'h0000);
      wr(A_CTRL, 16'h0000);
   endtask

   task automatic t_prescale;
      wr(A_CNT, 16'd0);
      wr(A_RLD, 16'd100);
      wr(A_PSC, 16'd2);
      wr(A_CTRL, RUN);
      wait_n(3);
      rd_chk(A_CNT, 16'd3, "R4 new divider not yet in use");
      wr(A_CTRL, 16'h0000);
      wr(A_EVT, 16'h0001);
      rd_chk(A_CNT, 16'd0, "R7 counter reset");
      rd_chk(A_STAT, 16'd1, "R7 flag from sw update");
      rd_chk(A_EVT, 16'd0, "R7 event reads zero");
      wr(A_STAT, 16'h0000);
      wr(A_CTRL, RUN);
      wait_n(8);
      rd_chk(A_CNT, 16'd2, "R4 divide by 3 mid");
      wait_n(1);
      rd_chk(A_CNT, 16'd3, "R4 divide by 3");
      wr(A_CTRL, 16'h0000);
      wr(A_PSC, 16'd0);
      wr(A_EVT, 16'h0001);
      wr(A_STAT, 16'h0000);
   endtask

   task automatic t_reload;
      wr(A_CNT, 16'd0);
      wr(A_RLD, 16'd3);
      wr(A_CTRL, RUN | BUF);
      wr(A_RLD, 16'd10);
      rd_chk(A_RLD, 16'd10, "R5 reload readback");
      wait_n(3);
      rd_chk(A_CNT, 16'd0, "R5 buffered keeps old limit");
      wait_n(6);
      rd_chk(A_CNT, 16'd6, "R5 new limit after update");
      wr(A_CTRL, 16'h0000);
      wr(A_STAT, 16'h0000);
      wr(A_CNT, 16'd0);
      wr(A_RLD, 16'd20);
      wr(A_CTRL, RUN);
      wr(A_RLD, 16'd4);
      wait_n(3);
      rd_chk(A_CNT, 16'd4, "R5 unbuffered before wrap");
      wait_n(1);
      rd_chk(A_CNT, 16'd0, "R5 unbuffered limit immediate");
      wr(A_CTRL, 16'h0000);
      wr(A_STAT, 16'h0000);
   endtask

   task automatic t_single;
      wr(A_CNT, 16'd0);
      wr(A_RLD, 16'd2);
      wr(A_CTRL, RUN | SGL);
      wait_n(3);
      rd_chk(A_CTRL, SGL, "R6 run cleared");
      rd_chk(A_STAT, 16'd1, "R6 flag");
      wait_n(4);
      rd_chk(A_CNT, 16'd0, "R6 stays stopped");
      wr(A_STAT, 16'h0000);
      wr(A_CTRL, 16'h0000);
   endtask

   task automatic t_noupd;
      wr(A_CNT, 16'd0);
      wr(A_RLD, 16'd2);
      wr(A_PSC, 16'd3);
      wr(A_CTRL, RUN | NOUP);
      wait_n(3);
      rd_chk(A_CNT, 16'd0, "R8 still wraps");
      rd_chk(A_STAT, 16'd0, "R8 no flag");
      chk("R8 no pulse", {15'b0, upd_pulse}, 16'h0000);
      wait_n(1);
      rd_chk(A_CNT, 16'd1, "R8 divider not transferred");
      wr(A_EVT, 16'h0001);
      rd_chk(A_CNT, 16'd0, "R8 sw update resets count");
      rd_chk(A_STAT, 16'd0, "R8 sw update no flag");
      wr(A_CTRL, 16'h0000);
      wr(A_PSC, 16'd0);
   endtask

   task automatic t_ovfonly;
      wr(A_CTRL, OVFO);
      wr(A_CNT, 16'd7);
      wr(A_PSC, 16'd1);
      wr(A_EVT, 16'h0001);
      rd_chk(A_CNT, 16'd0, "R9 sw update resets count");
      rd_chk(A_STAT, 16'd0, "R9 sw update leaves flag clear");
      wr(A_RLD, 16'd3);
      wr(A_CTRL, RUN | OVFO);
      wait_n(4);
      rd_chk(A_CNT, 16'd2, "R9 divider loaded by sw update");
      wait_n(4);
      rd_chk(A_STAT, 16'd1, "R9 overflow sets flag");
      wr(A_CTRL, 16'h0000);
      wr(A_PSC, 16'd0);
      wr(A_EVT, 16'h0001);
      wr(A_STAT, 16'h0000);
   endtask

   task automatic t_freeze;
      wr(A_CNT, 16'd0);
      wr(A_RLD, 16'd100);
      wr(A_CTRL, RUN | FRZ);
      wait_n(2);
      rd_chk(A_CNT, 16'd2, "R11 counting before halt");
      dbg_halt = 1'b1;
      wait_n(5);
      rd_chk(A_CNT, 16'd2, "R11 frozen");
      dbg_halt = 1'b0;
      wait_n(3);
      rd_chk(A_CNT, 16'd5, "R11 resumes");
      wr(A_CTRL, RUN);
      dbg_halt = 1'b1;
      wait_n(4);
      rd_chk(A_CNT, 16'd10, "R11 halt ignored without freeze");
      dbg_halt = 1'b0;
      wr(A_CTRL, 16'h0000);
   endtask

   task automatic t_misc;
      wr(A_CTRL, 16'hFFFF);
      rd_chk(A_CTRL, 16'h007F, "R12 reserved bits zero");
      wr(A_CTRL, 16'h0000);
      wr(A_STAT, 16'h0000);
      wr(A_EVT, 16'h0001);
      rd_chk(A_STAT, 16'd1, "R10 flag set");
      chk("R10 irq masked", {15'b0, irq}, 16'h0000);
      wr(A_CTRL, IE);
      chk("R10 irq enabled", {15'b0, irq}, 16'h0001);
      wr(A_STAT, 16'h0001);
      rd_chk(A_STAT, 16'd1, "R10 write one keeps flag");
      wr(A_STAT, 16'h0000);
      rd_chk(A_STAT, 16'd0, "R10 write zero clears");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_prescale();
      t_reload();
      t_single();
      t_noupd();
      t_ovfonly();
      t_freeze();
      t_misc();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule